// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level page table that sits in main memory. The address splits into three fields. The top ten bits pick an entry in the first-level table, the next nine bits pick an entry in the second-level table, and the low thirteen bits are the byte offset inside an 8 KB page. Each request also says whether the access is a load or a store. The walker fetches table entries through a read port that has at most one read outstanding. It answers every request with either a physical address or a fault code.

Two configuration registers steer the walk. The base register holds the physical address of the first-level table. The length register caps how many first-level entries may be used. Both registers can be written only while the privileged-mode input is high. A first-level entry holds a valid flag and the physical address of a second-level table. A second-level entry holds a valid flag, the access permissions and the physical frame number. Permissions are read only from the second-level entry.

Top module: `pt_walker`

## Requirements
- R1: After reset, `reqReady` is 1 and `respValid`, `memRdReq` and `privErr` are 0. The base and length registers reset to 0, so any request then ends with fault code 1 (out of range).
- R2: The first table read goes to address base + 4·p1, where p1 = `reqAddr[31:22]`.
- R3: In a first-level entry, bit 0 is the valid flag and bits [31:11] are the upper bits of the second-level table address. The second read goes to {entry[31:11], p2, 2'b00}, where p2 = `reqAddr[21:13]`. Bits [10:1] of the first-level entry have no effect, including the bit positions that carry permissions at the second level.
- R4: In a second-level entry, bit 0 is valid, bit 1 allows loads, bit 2 allows stores and bits [31:13] hold the frame number. A permitted access returns fault code 0 and `respPhys` = {frame, `reqAddr[12:0]`}.
- R5: If p1 is greater than or equal to the length register, the walk ends with fault code 1. No memory read is issued.
- R6: If the first-level entry is invalid, the walk ends with fault code 2 (not present) after exactly one read.
- R7: If the second-level entry is invalid, the walk ends with fault code 2 after two reads.
- R8: A store to an entry with bit 2 clear, or a load from an entry with bit 1 clear, ends with fault code 3 (protection).
- R9: A write with `privMode` high updates the register picked by `cfgSel`: 0 selects the base register (all 32 bits) and 1 selects the length register (`cfgWrData[10:0]`, so a length of 1024 allows every p1).
- R10: A write with `privMode` low leaves both registers unchanged. It drives `privErr` high for exactly the one following cycle.
- R11: A request is accepted only when `reqValid` and `reqReady` are both high. `reqReady` stays low from acceptance until the cycle after the one-cycle `respValid` pulse. A `reqValid` held during a walk starts nothing.
- R12: `memRdReq` and `memRdAddr` stay steady until the cycle in which `memRdAck` is seen, with at most one read in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqAddr | input | 32 | Logical address to translate |
| reqStore | input | 1 | 1 = store access, 0 = load access |
| respValid | output | 1 | One-cycle result strobe |
| respPhys | output | 32 | Physical address (0 on fault) |
| respFault | output | 2 | 0 none, 1 out of range, 2 not present, 3 protection |
| memRdReq | output | 1 | Table read request, held until acknowledged |
| memRdAddr | output | 32 | Physical address of the table entry |
| memRdAck | input | 1 | Read data valid this cycle |
| memRdData | input | 32 | Table entry returned by memory |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgSel | input | 1 | 0 = base register, 1 = length register |
| cfgWrData | input | 32 | Configuration write data |
| privMode | input | 1 | Writer is in privileged mode |
| privErr | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench probes the length boundary from both sides. It uses the last legal index, which must still be read, and the first illegal one, which must raise the fault with zero reads. A comparison that is off by one would either read a table it must not touch or reject a valid index. It counts reads after an invalid first-level entry, because a walker that skips the early stop would fetch a bogus second entry. It also runs all four load/store permission pairs, plus a first-level entry with its permission-position bits set, to catch checks placed on the wrong level or the wrong bit. It pushes refused writes to both registers and then translates, which exposes any register update that misses the privilege gate. Finally, it holds a request line high through a walk and stretches the memory latency, to show that the walker neither starts a second walk early nor moves its read address while waiting.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int L1_W     = 10;
  localparam int L2_W     = 9;
  localparam int OFF_W    = 13;
  localparam int ADDR_W   = L1_W + L2_W + OFF_W;
  localparam int LEN_W    = L1_W + 1;
  localparam int FRAME_W  = ADDR_W - OFF_W;
  localparam int TBL_W    = ADDR_W - (L2_W + 2);
  localparam int VALID_BIT = 0;
  localparam int RD_BIT    = 1;
  localparam int WR_BIT    = 2;

  typedef enum logic [1:0] {
    F_NONE   = 2'd0,
    F_RANGE  = 2'd1,
    F_ABSENT = 2'd2,
    F_PROT   = 2'd3
  } fault_e;

  typedef struct packed {
    logic   capReq;
    logic   capL1;
    logic   selL2;
    logic   setRes;
    fault_e code;
  } ctl_t;

  typedef struct packed {
    logic rangeErr;
    logic entValid;
    logic permOk;
  } sts_t;
endpackage

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  output sts_t              sts,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStore,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              privMode,
  output logic              privErr,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] respPhys,
  output logic [1:0]        respFault
);
  logic [ADDR_W-1:0] baseReg;
  logic [LEN_W-1:0]  lenReg;
  logic [ADDR_W-1:0] vaReg;
  logic              storeReg;
  logic [ADDR_W-1:0] l1AddrReg;
  logic [TBL_W-1:0]  tblReg;
  logic [ADDR_W-1:0] physReg;
  fault_e            faultReg;
  logic              privErrReg;

  logic [L1_W-1:0] p1In;
  logic [L2_W-1:0] p2Va;
  assign p1In = reqAddr[ADDR_W-1 -: L1_W];
  assign p2Va = vaReg[OFF_W +: L2_W];

  // configuration registers, gated by privilege
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg    <= '0;
      lenReg     <= '0;
      privErrReg <= 1'b0;
    end else begin
      privErrReg <= cfgWrEn && !privMode;
      if (cfgWrEn && privMode) begin
        if (cfgSel) lenReg  <= cfgWrData[LEN_W-1:0];
        else        baseReg <= cfgWrData;
      end
    end
  end

  // walk state captured on strobes from the control
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      storeReg  <= 1'b0;
      l1AddrReg <= '0;
      tblReg    <= '0;
      physReg   <= '0;
      faultReg  <= F_NONE;
    end else begin
      if (ctl.capReq) begin
        vaReg     <= reqAddr;
        storeReg  <= reqStore;
        l1AddrReg <= baseReg + ADDR_W'({p1In, 2'b00});
      end
      if (ctl.capL1)
        tblReg <= memRdData[ADDR_W-1 -: TBL_W];
      if (ctl.setRes) begin
        faultReg <= ctl.code;
        physReg  <= (ctl.code == F_NONE)
                    ? {memRdData[ADDR_W-1 -: FRAME_W], vaReg[OFF_W-1:0]}
                    : '0;
      end
    end
  end

  assign memRdAddr    = ctl.selL2 ? {tblReg, p2Va, 2'b00} : l1AddrReg;
  assign sts.rangeErr = {1'b0, p1In} >= lenReg;
  assign sts.entValid = memRdData[VALID_BIT];
  assign sts.permOk   = storeReg ? memRdData[WR_BIT] : memRdData[RD_BIT];

  assign respPhys  = physReg;
  assign respFault = faultReg;
  assign privErr   = privErrReg;

  // R10: a refused write must not move either register
  a_r10_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !privMode) |=> ($stable(baseReg) && $stable(lenReg)));
  // R10: a refused write is flagged on the next cycle
  a_r10_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !privMode) |=> privErr);
  // R4: a clean result keeps the page offset of the captured request
  a_r4_offset: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setRes && ctl.code == F_NONE) |=> (respPhys[OFF_W-1:0] == vaReg[OFF_W-1:0]));
endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  input  sts_t sts,
  output ctl_t ctl,
  output logic memRdReq,
  input  logic memRdAck,
  output logic respValid
);
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_DONE} state_e;
  state_e state, nextState;

  always_comb begin
    ctl       = '0;
    ctl.code  = F_NONE;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          ctl.capReq = 1'b1;
          if (sts.rangeErr) begin
            ctl.setRes = 1'b1;
            ctl.code   = F_RANGE;
            nextState  = S_DONE;
          end else begin
            nextState = S_L1;
          end
        end
      end
      S_L1: begin
        if (memRdAck) begin
          if (!sts.entValid) begin
            ctl.setRes = 1'b1;
            ctl.code   = F_ABSENT;
            nextState  = S_DONE;
          end else begin
            ctl.capL1 = 1'b1;
            nextState = S_L2;
          end
        end
      end
      S_L2: begin
        ctl.selL2 = 1'b1;
        if (memRdAck) begin
          ctl.setRes = 1'b1;
          if (!sts.entValid)    ctl.code = F_ABSENT;
          else if (!sts.permOk) ctl.code = F_PROT;
          else                  ctl.code = F_NONE;
          nextState = S_DONE;
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign reqReady  = (state == S_IDLE);
  assign respValid = (state == S_DONE);
  assign memRdReq  = (state == S_L1) || (state == S_L2);

  // R12: a pending read is held until acknowledged
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> memRdReq);
  // R11: the result strobe lasts one cycle and the walker is then free
  a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));
  // R11: no acceptance while a result is being returned
  a_r11_busy: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);
  // R5: out-of-range goes straight to the result without a read
  a_r5_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && sts.rangeErr) |=> (respValid && !memRdReq));
  // R6: an absent first-level entry ends the walk
  a_r6_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_L1 && memRdAck && !sts.entValid) |=> (respValid && !memRdReq));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStore,
  output logic              respValid,
  output logic [ADDR_W-1:0] respPhys,
  output logic [1:0]        respFault,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              privMode,
  output logic              privErr
);
  ctl_t ctl;
  sts_t sts;

  pt_walker_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .sts       (sts),
    .ctl       (ctl),
    .memRdReq  (memRdReq),
    .memRdAck  (memRdAck),
    .respValid (respValid)
  );

  pt_walker_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sts       (sts),
    .reqAddr   (reqAddr),
    .reqStore  (reqStore),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .privMode  (privMode),
    .privErr   (privErr),
    .memRdAddr (memRdAddr),
    .memRdData (memRdData),
    .respPhys  (respPhys),
    .respFault (respFault)
  );

  // R12: read address does not move while the read is pending
  a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> $stable(memRdAddr));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqStore = 1'b0;
  logic        respValid;
  logic [31:0] respPhys;
  logic [1:0]  respFault;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdAck = 1'b0;
  logic [31:0] memRdData = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        privMode = 1'b0;
  logic        privErr;

  int compared = 0;
  int mismatched = 0;
  int memLat = 0;
  int rdCount = 0;
  logic [31:0] rdLog [2];
  logic [31:0] memArr [int unsigned];
  int cycles = 0;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqStore(reqStore), .respValid(respValid),
    .respPhys(respPhys), .respFault(respFault), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdAck(memRdAck), .memRdData(memRdData),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .privMode(privMode), .privErr(privErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // memory model: answers after memLat idle cycles, one read at a time
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memRdAck) begin
        memRdAck = 1'b0;
      end else if (memRdReq) begin
        if (waitCnt >= memLat) begin
          memRdData = memArr.exists(memRdAddr) ? memArr[memRdAddr] : 32'h0;
          if (rdCount < 2) rdLog[rdCount] = memRdAddr;
          rdCount++;
          memRdAck = 1'b1;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [31:0] mkVa(input int p1, input int p2, input int off);
    return (32'(p1) << 22) | (32'(p2) << 13) | 32'(off);
  endfunction

  task automatic cfgWrite(input logic sel, input logic [31:0] data, input logic priv);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data; privMode = priv;
    @(negedge clk);
    cfgWrEn = 1'b0; privMode = 1'b0;
  endtask

  // runs one translation; holdReq keeps reqValid high through the walk
  task automatic translate(input logic [31:0] va, input logic st, input bit holdReq,
                           output logic [31:0] phys, output logic [1:0] flt,
                           output int nRd);
    int guard = 0;
    @(negedge clk);
    rdCount = 0;
    reqValid = 1'b1; reqAddr = va; reqStore = st;
    @(negedge clk);
    if (!holdReq) reqValid = 1'b0;
    else reqAddr = va ^ 32'h0040_0000;
    while (!respValid && guard < 60) begin
      check(reqReady == 1'b0, "R11", "ready during walk", 32'(reqReady), 32'h0);
      @(negedge clk);
      guard++;
    end
    check(respValid == 1'b1, "R11", "response arrived", 32'(respValid), 32'h1);
    check(reqReady == 1'b0, "R11", "ready with response", 32'(reqReady), 32'h0);
    phys = respPhys; flt = respFault; nRd = rdCount;
    reqValid = 1'b0;
    @(negedge clk);
    check(respValid == 1'b0 && reqReady == 1'b1, "R11", "pulse ends, idle again",
          {30'h0, respValid, reqReady}, 32'h1);
  endtask

  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] TBL  = 32'h0002_0800;

  task automatic t_reset();
    logic [31:0] ph; logic [1:0] f; int n;
    check(reqReady == 1'b1, "R1", "ready after reset", 32'(reqReady), 32'h1);
    check(respValid == 1'b0 && memRdReq == 1'b0 && privErr == 1'b0, "R1", "idle outputs",
          {29'h0, respValid, memRdReq, privErr}, 32'h0);
    translate(mkVa(0, 0, 0), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd1, "R1", "fault with zero length", 32'(f), 32'h1);
    check(n == 0, "R5", "no read when out of range", 32'(n), 32'h0);
  endtask

  task automatic t_refused();
    logic [31:0] ph; logic [1:0] f; int n;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgWrData = 32'd16; privMode = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check(privErr == 1'b1, "R10", "flag after refused write", 32'(privErr), 32'h1);
    @(negedge clk);
    check(privErr == 1'b0, "R10", "flag lasts one cycle", 32'(privErr), 32'h0);
    translate(mkVa(0, 0, 0), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd1 && n == 0, "R10", "length unchanged by refused write", 32'(f), 32'h1);
  endtask

  task automatic t_success(input int lat);
    logic [31:0] ph; logic [1:0] f; int n;
    logic [31:0] va;
    memLat = lat;
    va = mkVa(3, 5, 13'h123);
    memArr[BASE + 32'd12] = TBL | 32'h1;
    memArr[TBL + 32'd20]  = (32'h1ABCD << 13) | 32'h7;
    translate(va, 1'b0, 1'b0, ph, f, n);
    check(n == 2, "R3", "two reads", 32'(n), 32'h2);
    check(rdLog[0] == BASE + 32'd12, "R2", "first-level address", rdLog[0], BASE + 32'd12);
    check(rdLog[1] == TBL + 32'd20, "R3", "second-level address", rdLog[1], TBL + 32'd20);
    check(f == 2'd0, "R4", "no fault", 32'(f), 32'h0);
    check(ph == ((32'h1ABCD << 13) | 32'h123), "R4", "physical address", ph,
          (32'h1ABCD << 13) | 32'h123);
    memLat = 0;
  endtask

  task automatic t_bounds();
    logic [31:0] ph; logic [1:0] f; int n;
    translate(mkVa(15, 0, 0), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd2 && n == 1, "R5", "last legal index is read", {f, 30'(n)}, {2'd2, 30'd1});
    translate(mkVa(16, 0, 0), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd1, "R5", "first illegal index faults", 32'(f), 32'h1);
    check(n == 0, "R5", "no read beyond length", 32'(n), 32'h0);
  endtask

  task automatic t_absent();
    logic [31:0] ph; logic [1:0] f; int n;
    memArr[BASE + 32'd16] = TBL | 32'h6;     // p1=4: valid bit clear
    translate(mkVa(4, 1, 0), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd2, "R6", "invalid first level", 32'(f), 32'h2);
    check(n == 1, "R6", "single read only", 32'(n), 32'h1);
    memArr[BASE + 32'd20] = TBL | 32'h1;     // p1=5: second entry p2=9 absent
    translate(mkVa(5, 9, 0), 1'b1, 1'b0, ph, f, n);
    check(f == 2'd2 && n == 2, "R7", "invalid second level", {f, 30'(n)}, {2'd2, 30'd2});
  endtask

  task automatic t_protect();
    logic [31:0] ph; logic [1:0] f; int n;
    memArr[BASE + 32'd24] = TBL | 32'h7;     // p1=6, permission-position bits set at first level
    memArr[TBL + 32'd40] = (32'h00111 << 13) | 32'h3;  // p2=10 readable only
    memArr[TBL + 32'd44] = (32'h00222 << 13) | 32'h5;  // p2=11 writable only
    translate(mkVa(6, 10, 4), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd0 && ph == ((32'h111 << 13) | 32'h4), "R8", "load on read-only page", ph,
          (32'h111 << 13) | 32'h4);
    translate(mkVa(6, 10, 4), 1'b1, 1'b0, ph, f, n);
    check(f == 2'd3, "R8", "store on read-only page", 32'(f), 32'h3);
    translate(mkVa(6, 11, 8), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd3, "R8", "load on write-only page", 32'(f), 32'h3);
    translate(mkVa(6, 11, 8), 1'b1, 1'b0, ph, f, n);
    check(f == 2'd0 && ph == ((32'h222 << 13) | 32'h8), "R8", "store on write-only page", ph,
          (32'h222 << 13) | 32'h8);
    memArr[BASE + 32'd28] = TBL | 32'h1;     // p1=7: same table, no extra bits
    translate(mkVa(7, 11, 8), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd3, "R3", "first-level bits do not grant access", 32'(f), 32'h3);
  endtask

  task automatic t_busy();
    logic [31:0] ph; logic [1:0] f; int n;
    memLat = 3;
    translate(mkVa(3, 5, 13'h0AB), 1'b0, 1'b1, ph, f, n);
    check(n == 2, "R12", "one walk only under held request", 32'(n), 32'h2);
    check(ph == ((32'h1ABCD << 13) | 32'h0AB), "R11", "result from first request", ph,
          (32'h1ABCD << 13) | 32'h0AB);
    memLat = 0;
  endtask

  task automatic t_fullLen();
    logic [31:0] ph; logic [1:0] f; int n;
    cfgWrite(1'b1, 32'd1024, 1'b1);
    translate(mkVa(1023, 0, 0), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd2 && n == 1, "R9", "length 1024 admits index 1023", {f, 30'(n)},
          {2'd2, 30'd1});
    cfgWrite(1'b0, 32'h0005_0000, 1'b0);
    translate(mkVa(3, 5, 0), 1'b0, 1'b0, ph, f, n);
    check(f == 2'd0 && rdLog[0] == BASE + 32'd12, "R10", "base unchanged by refused write",
          rdLog[0], BASE + 32'd12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_refused();
    cfgWrite(1'b0, BASE, 1'b1);
    cfgWrite(1'b1, 32'd16, 1'b1);
    t_success(0);
    t_success(4);
    t_bounds();
    t_absent();
    t_protect();
    t_busy();
    t_fullLen();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule